// File: doc/BRIEF.md
# Modulo-N Increment/Clear Counter with Rollover

This block is a synchronous counter that steps through the values 0 to N-1 and then starts again at 0. Two control inputs drive it on each rising clock edge. An increment request advances the value by one. A clear request returns it to zero. When neither is asserted, the value is held.

Two flags let several instances be chained into a wider counter. The terminal flag depends only on the current value. The rollover flag is combinational: it is high in the cycle that ends with the counter wrapping back to zero. To chain counters, connect one stage's rollover flag to the next stage's increment input. This gives a multi-digit counter in which every stage runs from the same clock.

Increment and clear can be asserted together. A build-time parameter selects what the counter then does: it can ignore both, let the increment win, or let the clear win.

Top module: `modn_counter`

## Requirements
- R1: With `inc` and `clr` both low, `count` keeps its value across a rising clock edge.
- R2: With `inc` high and `clr` low and `count` below N-1, `count` increases by one on the rising edge.
- R3: With `clr` high and `inc` low, `count` becomes 0 on the rising edge, whatever its previous value.
- R4: With `inc` and `clr` both high, the parameter `TIE_RULE` decides the result. 0 holds the value, 1 performs the increment (including the wrap), and 2 clears to 0.
- R5: An increment applied at N-1 takes `count` to 0, and `count` never exceeds N-1.
- R6: `at_term` is high exactly when `count` equals N-1, whatever the inputs.
- R7: `wrap` is high in the same cycle as an increment that takes effect while `count` is N-1, and is low at every other time.
- R8: While `clr` is high, `wrap` stays low unless `TIE_RULE` is 1.
- R9: Driving `rst_n` low sets `count` to 0 at once, without waiting for a clock edge.
- R10: `count` is ceil(log2 N) bits wide, so every value up to N-1 is representable. The parameter check rejects N below 2 and any `TIE_RULE` other than 0, 1 or 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| inc | input | 1 | Increment request |
| clr | input | 1 | Synchronous clear request |
| count | output | ceil(log2 N) | Current count value |
| at_term | output | 1 | High while count equals N-1 |
| wrap | output | 1 | High in the cycle whose edge wraps count from N-1 to 0 |

## Verification
Four counters run side by side on shared inputs. Three use N=4, one per tie rule. The fourth uses N=6, so the wrap comes before the register's natural overflow. A directed increment walk steps each counter through every state and across the wrap. This separates a correct terminal decode from plain binary overflow.

A sweep then applies all four input combinations at every state. The three tie rules can only differ where both requests are high, so this sweep shows whether the rules behave differently. It also shows whether a clear at the terminal value wrongly raises `wrap`.

Weighted random input sequences follow, with clear made rare. These give long increment runs with occasional clears. An asynchronous reset is then applied between clock edges to confirm that it acts without waiting for an edge.

// File: rtl/modn_counter.sv
`timescale 1ns/1ps
module modn_counter #(
  parameter int MODULUS  = 4,
  parameter int TIE_RULE = 0,
  localparam int W = (MODULUS < 2) ? 1 : $clog2(MODULUS)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         clr,
  output logic [W-1:0] count,
  output logic         at_term,
  output logic         wrap
);
  localparam logic [W-1:0] TOP = W'(MODULUS - 1);

  generate
    if (MODULUS < 2) begin : g_bad_mod
      $error("modn_counter: MODULUS must be at least 2");
    end
    if (TIE_RULE < 0 || TIE_RULE > 2) begin : g_bad_rule
      $error("modn_counter: TIE_RULE must be 0, 1 or 2");
    end
  endgenerate

  logic [W-1:0] cnt_q;
  logic         step_up, to_zero;

  assign step_up = inc & (~clr | (TIE_RULE == 1));
  assign to_zero = clr & (~inc | (TIE_RULE == 2));
  assign at_term = (cnt_q == TOP);
  assign wrap    = at_term & step_up;
  assign count   = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (to_zero) cnt_q <= '0;
    else if (step_up) cnt_q <= at_term ? '0 : cnt_q + 1'b1;
  end
endmodule

module modn_counter_chk #(
  parameter int MODULUS  = 4,
  parameter int TIE_RULE = 0,
  localparam int W = (MODULUS < 2) ? 1 : $clog2(MODULUS)
) (
  input logic         clk,
  input logic         rst_n,
  input logic         inc,
  input logic         clr,
  input logic [W-1:0] count,
  input logic         at_term,
  input logic         wrap
);
  localparam logic [W-1:0] TOP = W'(MODULUS - 1);

  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !clr) |=> $stable(count));

  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr && count != TOP) |=> (count == W'($past(count) + 1)));

  assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !inc) |=> (count == '0));

  generate
    if (TIE_RULE == 0) begin : g_tie_hold
      assert_tie_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && clr) |=> $stable(count));
    end else if (TIE_RULE == 1) begin : g_tie_inc
      assert_tie_inc_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && clr && count != TOP) |=> (count == W'($past(count) + 1)));
    end else begin : g_tie_clr
      assert_tie_clr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && clr) |=> (count == '0));
    end
  endgenerate

  assert_wrap_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (count == '0));

  assert_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    count <= TOP);

  assert_term_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(at_term) |-> $past(inc));

  assert_wrap_cond_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |-> (at_term && inc));

  generate
    if (TIE_RULE != 1) begin : g_mask
      assert_clr_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |-> !wrap);
    end
  endgenerate

  assert_reset_R9: assert property (@(posedge clk)
    !rst_n |-> (count == '0));
endmodule

bind modn_counter modn_counter_chk #(.MODULUS(MODULUS), .TIE_RULE(TIE_RULE)) u_chk (.*);

// File: tb/tb_modn_counter.sv
`timescale 1ns/1ps
module tb_modn_counter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic inc = 1'b0;
  logic clr = 1'b0;
  always #2 clk = ~clk;

  logic [1:0] c0, c1, c2;
  logic [2:0] c3;
  logic [3:0] term, wr;
  logic [2:0] cnt [4];

  modn_counter #(.MODULUS(4), .TIE_RULE(0)) dut
    (.clk(clk), .rst_n(rst_n), .inc(inc), .clr(clr), .count(c0), .at_term(term[0]), .wrap(wr[0]));
  modn_counter #(.MODULUS(4), .TIE_RULE(1)) dut_iw
    (.clk(clk), .rst_n(rst_n), .inc(inc), .clr(clr), .count(c1), .at_term(term[1]), .wrap(wr[1]));
  modn_counter #(.MODULUS(4), .TIE_RULE(2)) dut_cw
    (.clk(clk), .rst_n(rst_n), .inc(inc), .clr(clr), .count(c2), .at_term(term[2]), .wrap(wr[2]));
  modn_counter #(.MODULUS(6), .TIE_RULE(0)) dut_m6
    (.clk(clk), .rst_n(rst_n), .inc(inc), .clr(clr), .count(c3), .at_term(term[3]), .wrap(wr[3]));

  assign cnt[0] = {1'b0, c0};
  assign cnt[1] = {1'b0, c1};
  assign cnt[2] = {1'b0, c2};
  assign cnt[3] = c3;

  int pol [4] = '{0, 1, 2, 0};
  int modn [4] = '{4, 4, 4, 6};
  int mdl [4];
  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;
  bit prev_i = 1'b0, prev_c = 1'b0;

  function automatic int nxt(int cur, bit i, bit c, int p, int n);
    bit up, zero;
    up   = i && (!c || p == 1);
    zero = c && (!i || p == 2);
    if (zero) return 0;
    if (up)   return (cur == n - 1) ? 0 : cur + 1;
    return cur;
  endfunction

  function automatic bit rolls(int cur, bit i, bit c, int p, int n);
    return (cur == n - 1) && i && (!c || p == 1);
  endfunction

  function automatic string cnt_tag(bit i, bit c, int k, int e);
    if (k == 3 && e >= 4) return "R10";
    if (i && c) return "R4";
    if (c) return "R3";
    if (i) return (e == 0) ? "R5" : "R2";
    return "R1";
  endfunction

  task automatic chk(string req, string what, int k, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s inst%0d actual=%0d expected=%0d", req, what, k, act, exp);
    end
  endtask

  task automatic step(bit i, bit c);
    @(negedge clk);
    for (int k = 0; k < 4; k++)
      chk(cnt_tag(prev_i, prev_c, k, mdl[k]), "count", k, int'(cnt[k]), mdl[k]);
    inc = i; clr = c;
    #1;
    for (int k = 0; k < 4; k++) begin
      chk("R6", "at_term", k, int'(term[k]), int'(mdl[k] == modn[k] - 1));
      chk((c && pol[k] != 1) ? "R8" : "R7", "wrap", k, int'(wr[k]),
          int'(rolls(mdl[k], i, c, pol[k], modn[k])));
      mdl[k] = nxt(mdl[k], i, c, pol[k], modn[k]);
    end
    prev_i = i; prev_c = c;
  endtask

  task automatic async_reset();
    @(negedge clk);
    #1 rst_n = 1'b0;
    #0.5;
    for (int k = 0; k < 4; k++) begin
      chk("R9", "count", k, int'(cnt[k]), 0);
      mdl[k] = 0;
    end
    inc = 1'b0; clr = 1'b0; prev_i = 1'b0; prev_c = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int k = 0; k < 4; k++) mdl[k] = 0;
    inc = 1'b1;
    #5;
    for (int k = 0; k < 4; k++) chk("R9", "count", k, int'(cnt[k]), 0);
    inc = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;

    for (int s = 0; s < 14; s++) step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);

    for (int start = 0; start < 6; start++) begin
      for (int combo = 0; combo < 4; combo++) begin
        step(1'b0, 1'b1);
        for (int s = 0; s < start; s++) step(1'b1, 1'b0);
        step(combo[0], combo[1]);
        step(1'b0, 1'b0);
      end
    end

    for (int s = 0; s < 3000; s++) begin
      bit ri, rc;
      ri = ($urandom % 4) != 0;
      rc = ($urandom % 8) == 0;
      step(ri, rc);
    end

    async_reset();
    for (int s = 0; s < 8; s++) step(1'b1, 1'b1);
    for (int s = 0; s < 8; s++) step(1'b1, 1'b0);
    step(1'b0, 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule